// File: doc/BRIEF.md
# I2S Slave Stereo Receiver with Word-Length Adaptation

This block receives two-channel PCM audio over a three-wire I2S link in which it acts as the slave. An external master drives the serial clock, the word select and the serial data. The block samples all three in its own system clock domain, detects rising edges of the serial clock, and captures word select and data on those edges.

A word starts at a word-select transition. The bit sampled on the edge where the transition is first seen is the final bit of the word that is ending. The next bit is the MSB of the new word. Each word is shifted MSB first into the top of a W-bit result. The receiver keeps a programmable number of bits (16, 18, 20 or 24). It drops any extra bits the transmitter sends, and zeros any bits it does not receive.

A left word and the right word that follows it are presented together as one stereo pair on a valid/ready output. A pair that arrives before the previous one is taken replaces it and raises a one-cycle overrun pulse. After reset, or after a malformed (empty) word, nothing is emitted until a complete left word has been framed.

Top module: `i2s_slave_rx`

## Requirements
- R1: `len_sel` picks the kept word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The kept bits occupy the top of the W-bit outputs.
- R2: The first data bit after the word-select transition edge lands in output bit W-1. Later bits fill downward, MSB first.
- R3: When the transmitter sends more bits than the kept length, only its leading bits are kept and the excess low-order bits are dropped.
- R4: When the transmitter sends fewer bits than the kept length, the output bits below the received ones are zero.
- R5: Data framed while word select is low appears on `out_left`. Data framed while word select is high appears on `out_right`.
- R6: Word boundaries come only from word-select transitions, so the left and right words may have unequal and arbitrary lengths.
- R7: After reset, and after a word in which no bit was stored before the next transition, no pair is emitted until a complete left word followed by a right word has been received.
- R8: If a new pair completes while `out_valid` is still high and `out_ready` is low, the new pair replaces the old one and `overrun` pulses high for one cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the data stays stable unless an overrun replaces it. A cycle with both high consumes the pair.
- R10: After reset, `out_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_in | input | 1 | Serial bit clock from the master |
| ws_in | input | 1 | Word select from the master (low = left) |
| sd_in | input | 1 | Serial data, MSB first |
| len_sel | input | 2 | Kept word length code |
| out_left | output | W | Left sample, left-justified |
| out_right | output | W | Right sample, left-justified |
| out_valid | output | 1 | Stereo pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| overrun | output | 1 | One-cycle pulse when an unread pair is replaced |

## Verification
The two situations hardest to reach from the ports are an overrun and an empty word. An overrun needs two full stereo frames to complete while the consumer holds ready low. An empty word needs a word-select change on the very slot after the previous transition. The stimulus reaches the first by dropping `out_ready` across two directed frames. It reaches the second by sending a one-slot right word between two left words, then confirms that the orphaned left sample never appears. Randomized frames with random transmitter lengths and length codes cover truncation and zero fill against a bench model of the justified result.

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_in,
  input  logic         ws_in,
  input  logic         sd_in,
  input  logic [1:0]   len_sel,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         overrun
);
  localparam int CW = $clog2(W + 1);

  logic [2:0]    sck_sr;
  logic [1:0]    ws_sr, sd_sr;
  logic          ws_prev, in_word, have_left;
  logic [CW-1:0] cnt, wlen;
  logic [W-1:0]  shreg, left_hold, word_now;

  wire sck_rise = sck_sr[1] & ~sck_sr[2];
  wire ws_s     = ws_sr[1];
  wire sd_s     = sd_sr[1];
  wire bnd      = sck_rise && (ws_s != ws_prev);
  wire good     = in_word && (cnt != '0);

  always_comb begin
    case (len_sel)
      2'd0:    wlen = CW'(16);
      2'd1:    wlen = CW'(18);
      2'd2:    wlen = CW'(20);
      default: wlen = CW'(24);
    endcase
  end

  always_comb begin
    word_now = shreg;
    if (cnt < wlen) word_now[W-1-int'(cnt)] = sd_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sr    <= '0;
      ws_sr     <= '0;
      sd_sr     <= '0;
      ws_prev   <= 1'b0;
      in_word   <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      left_hold <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      sck_sr  <= {sck_sr[1:0], sck_in};
      ws_sr   <= {ws_sr[0], ws_in};
      sd_sr   <= {sd_sr[0], sd_in};
      overrun <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (sck_rise) begin
        ws_prev <= ws_s;
        if (bnd) begin
          shreg   <= '0;
          cnt     <= '0;
          in_word <= 1'b1;
          if (!good) begin
            have_left <= 1'b0;
          end else if (!ws_prev) begin
            left_hold <= word_now;
            have_left <= 1'b1;
          end else if (have_left) begin
            out_left  <= left_hold;
            out_right <= word_now;
            out_valid <= 1'b1;
            overrun   <= out_valid && !out_ready;
            have_left <= 1'b0;
          end
        end else begin
          shreg <= word_now;
          if (cnt < wlen) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_ovr_keeps_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> out_valid);

  p_hold_until_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && (overrun || ($stable(out_left) && $stable(out_right))));

  p_pair_needs_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(have_left));

  p_ws_edge_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> ws_prev == $past(ws_s));

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));
endmodule

// File: tb/i2s_slave_rx_test.sv
module i2s_slave_rx_test;
  localparam int W = 24;
  logic clk = 0, rst_n = 0, sck = 0, ws = 1, sd = 0, ready = 1;
  logic [1:0] len_sel = 2'd3;
  logic [W-1:0] out_left, out_right;
  logic out_valid, overrun;
  int total = 0, bad = 0, ovr = 0;
  logic [W-1:0] gl[$], gr[$], el[$], er[$];

  always #4 clk = ~clk;

  i2s_slave_rx #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .ws_in(ws), .sd_in(sd),
    .len_sel(len_sel), .out_left(out_left), .out_right(out_right),
    .out_valid(out_valid), .out_ready(ready), .overrun(overrun));

  always @(negedge clk) if (rst_n) begin
    if (out_valid && ready) begin gl.push_back(out_left); gr.push_back(out_right); end
    if (overrun) ovr++;
  end

  function automatic int lenof(logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
  endfunction

  function automatic logic [W-1:0] expw(logic [31:0] d, int n, int len);
    logic [W-1:0] r = '0;
    for (int i = 0; i < len; i++) if (i < n) r[W-1-i] = d[n-1-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic slot(input logic w, input logic b);
    @(negedge clk); sck = 0; ws = w; sd = b;
    repeat (4) @(negedge clk); sck = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic word(input logic c, input int n, input logic [31:0] d);
    for (int j = 0; j < n; j++) slot((j == n-1) ? ~c : c, d[n-1-j]);
  endtask

  task automatic pair(input int nl, input logic [31:0] dl, input int nr, input logic [31:0] dr, input bit keep);
    word(1'b0, nl, dl);
    word(1'b1, nr, dr);
    if (keep) begin
      el.push_back(expw(dl, nl, lenof(len_sel)));
      er.push_back(expw(dr, nr, lenof(len_sel)));
    end
  endtask

  task automatic drain(input string req);
    repeat (30) @(negedge clk);
    check({req, " pair count"}, gl.size(), el.size());
    for (int i = 0; i < el.size() && i < gl.size(); i++) begin
      check({req, " left"}, gl[i], el[i]);
      check({req, " right"}, gr[i], er[i]);
    end
    gl.delete(); gr.delete(); el.delete(); er.delete();
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 valid after reset", out_valid, 0);
    check("R10 overrun after reset", overrun, 0);

    // R7: leading right fragment after reset is discarded
    word(1'b1, 5, 32'h15);
    for (int s = 0; s < 4; s++) begin
      len_sel = s[1:0];
      pair(lenof(len_sel), 32'hA5C3F1 ^ s, lenof(len_sel), 32'h3C96E7 + s, 1'b1);
    end
    drain("R1 R2 R5 exact lengths");

    len_sel = 2'd0;
    pair(32, 32'hDEADBEEF, 28, 32'h0ABCDEF1, 1'b1);
    drain("R3 truncation");

    len_sel = 2'd3;
    pair(8, 32'h000000C5, 12, 32'h00000A5F, 1'b1);
    drain("R4 zero fill");

    len_sel = 2'd2;
    pair(10, 32'h2D3, 30, 32'h2BCD_1234, 1'b1);
    drain("R6 unequal word lengths");

    // R7: empty right word drops the preceding left
    len_sel = 2'd3;
    word(1'b0, 24, 32'h111111);
    word(1'b1, 1, 32'h1);
    pair(24, 32'h777777, 24, 32'h888888, 1'b1);
    drain("R7 empty word resync");

    // R8 R9: hold and overrun
    ready = 0; ovr = 0;
    pair(24, 32'h123456, 24, 32'h654321, 1'b0);
    repeat (20) @(negedge clk);
    check("R9 valid held", out_valid, 1);
    check("R9 left stable", out_left, 32'h123456);
    pair(24, 32'hABCDEF, 24, 32'hFEDCBA, 1'b0);
    repeat (20) @(negedge clk);
    check("R8 overrun pulses", ovr, 1);
    check("R8 left replaced", out_left, 32'hABCDEF);
    check("R8 right replaced", out_right, 32'hFEDCBA);
    ready = 1;
    el.push_back(24'hABCDEF); er.push_back(24'hFEDCBA);
    drain("R9 accepted once");
    check("R9 valid cleared", out_valid, 0);

    // R3 R4 random lengths
    for (int b = 0; b < 4; b++) begin
      len_sel = 2'($urandom % 4);
      for (int k = 0; k < 6; k++)
        pair(8 + ($urandom % 25), $urandom, 8 + ($urandom % 25), $urandom, 1'b1);
      drain("R3 R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule